// File: doc/BRIEF.md
# Horizontal Sync Polarity Normalizer

This block sits behind the pixel sampler of a video capture path. It takes a horizontal sync of unknown polarity, finds out which of its two phases is the real sync pulse, and rebuilds a clean pulse of programmable width and polarity from each leading edge of that pulse. The rebuilt sync is held back so that its leading edge leaves the block in the same clock as the pixel sampled together with the incoming sync transition. The block also carries a fixed four-stage pixel data pipe.

A second output sends a one-clock reference strobe per active sync edge to the pixel clock generator. While a coast request is asserted, these strobes are withheld so that the clock generator free-runs through disturbed sync intervals. The raw sync and the coast request may both be asynchronous. Each one passes through a two-flop synchronizer before use.

Top module: `hsync_normalizer`

## Requirements
- R1: While reset is asserted, `pol_locked`, `pol_active_high`, `ref_strobe` and `pix_out` are 0, and `hsync_out` sits at its inactive level: 0 when `cfg_out_active_high` is 1, and 1 when it is 0.
- R2: A line spans from one rising edge of the synchronized sync to the next. For each line the high and low clock counts are compared. If the high time is strictly shorter, the candidate is active high (`pol_active_high` = 1). Otherwise, including a tie, the candidate is active low. `pol_locked` goes to 1 once two consecutive lines give the same candidate, and it stays at 1 until reset.
- R3: One line whose duty cycle points the other way does not change `pol_active_high`. Two consecutive such lines do change it. The detected polarity only changes in the clock after a rising input edge.
- R4: `cfg_out_active_high` = 1 makes the rebuilt pulse drive `hsync_out` high. A value of 0 drives it low.
- R5: Each pulse lasts `cfg_pulse_width` pixel clocks. A value of 0 gives a pulse of 1 clock.
- R6: `pix_out` is `pix_in` delayed by four clocks. The leading edge of `hsync_out` appears in the same clock as the `pix_out` sample that entered together with the active sync transition on `hsync_in`.
- R7: If a new active edge arrives while a pulse is running, the count restarts. The pulse ends `cfg_pulse_width` clocks after the latest leading edge, without a second leading edge.
- R8: After lock, each active edge gives exactly one `ref_strobe` clock, unless `coast_in` (synchronized with the same latency as the sync) is asserted, in which case no strobe is produced. Coast does not suppress `hsync_out` pulses.
- R9: Before `pol_locked` is 1, no `hsync_out` pulse and no `ref_strobe` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync, any polarity, asynchronous |
| coast_in | input | 1 | Coast request, active high, asynchronous |
| pix_in | input | DATA_W | Pixel sample entering the data pipe |
| cfg_out_active_high | input | 1 | Output sync polarity, 1 = active high |
| cfg_pulse_width | input | 8 | Output pulse width in pixel clocks, 0 acts as 1 |
| hsync_out | output | 1 | Rebuilt, aligned sync |
| ref_strobe | output | 1 | One-clock reference edge strobe to the clock generator |
| pix_out | output | DATA_W | Pixel sample after the four-stage pipe |
| pol_locked | output | 1 | Polarity has been detected |
| pol_active_high | output | 1 | Detected input polarity, 1 = active high |

## Verification
The embedded properties are checked on every clock. They cover these points: the lock flag never falls, the detected polarity moves only after a rising input edge, a pulse start always leaves the pulse active, and a pulse only ends once its count is spent. They also check that a strobe never follows a synchronized coast and never comes before lock. The bench scenarios are needed for the rest: which polarity a given duty cycle yields (ties included), and that a single odd line is rejected. They also show the exact pulse width for zero and non-zero settings, the clock-exact alignment against the data pipe, and that restarting a pulse stretches it rather than doubling it.

// File: rtl/hsn_pkg.sv
package hsn_pkg;

    localparam int HSN_CNT_W   = 12;
    localparam int HSN_WIDTH_W = 8;

    typedef struct packed {
        logic                 prev;
        logic                 seen;
        logic [HSN_CNT_W-1:0] hi_cnt;
        logic [HSN_CNT_W-1:0] lo_cnt;
        logic                 cand;
        logic                 cand_ok;
        logic                 pol_valid;
        logic                 pol_high;
    } pol_st_t;

    typedef struct packed {
        logic                   active;
        logic [HSN_WIDTH_W-1:0] remain;
    } pulse_st_t;

endpackage

// File: rtl/hsn_sync.sv
module hsn_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hsn_pol_detect.sv
module hsn_pol_detect
    import hsn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_s,
    output logic active_edge,
    output logic pol_valid,
    output logic pol_high
);
    pol_st_t st_d, st_q;
    logic    rise, fall, cand_now;

    assign rise     = hs_s & ~st_q.prev;
    assign fall     = ~hs_s & st_q.prev;
    assign cand_now = (st_q.hi_cnt < st_q.lo_cnt);

    always_comb begin
        st_d      = st_q;
        st_d.prev = hs_s;
        if (rise) begin
            if (st_q.seen) begin
                if (st_q.cand_ok && (st_q.cand == cand_now)) begin
                    st_d.pol_valid = 1'b1;
                    st_d.pol_high  = cand_now;
                end
                st_d.cand    = cand_now;
                st_d.cand_ok = 1'b1;
            end
            st_d.seen   = 1'b1;
            st_d.hi_cnt = {{(HSN_CNT_W-1){1'b0}}, 1'b1};
            st_d.lo_cnt = '0;
        end else if (hs_s) begin
            if (st_q.hi_cnt != '1) st_d.hi_cnt = st_q.hi_cnt + 1'b1;
        end else begin
            if (st_q.lo_cnt != '1) st_d.lo_cnt = st_q.lo_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_edge = st_q.pol_valid & (st_q.pol_high ? rise : fall);
    assign pol_valid   = st_q.pol_valid;
    assign pol_high    = st_q.pol_high;

    // R2: lock is sticky
    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pol_valid |=> st_q.pol_valid);

    // R3: polarity only moves after a rising input edge
    assert_pol_moves_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pol_high != $past(st_q.pol_high)) |-> $past(rise));
endmodule

// File: rtl/hsn_pulse_gen.sv
module hsn_pulse_gen
    import hsn_pkg::*;
#(
    parameter int EDGE_DLY = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   edge_in,
    input  logic [HSN_WIDTH_W-1:0] cfg_width,
    input  logic                   cfg_pol_high,
    output logic                   hs_out
);
    pulse_st_t              pls_d, pls_q;
    logic                   start;
    logic [HSN_WIDTH_W-1:0] w_eff;

    generate
        if (EDGE_DLY > 0) begin : g_dly
            logic [EDGE_DLY-1:0] dly_q;
            if (EDGE_DLY == 1) begin : g_one
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) dly_q <= '0;
                    else        dly_q <= edge_in;
                end
            end else begin : g_many
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) dly_q <= '0;
                    else        dly_q <= {dly_q[EDGE_DLY-2:0], edge_in};
                end
            end
            assign start = dly_q[EDGE_DLY-1];
        end else begin : g_nodly
            assign start = edge_in;
        end
    endgenerate

    assign w_eff = (cfg_width == '0) ? {{(HSN_WIDTH_W-1){1'b0}}, 1'b1} : cfg_width;

    always_comb begin
        pls_d = pls_q;
        if (start) begin
            pls_d.active = 1'b1;
            pls_d.remain = w_eff - 1'b1;
        end else if (pls_q.active) begin
            if (pls_q.remain == '0) pls_d.active = 1'b0;
            else                    pls_d.remain = pls_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pls_q <= '0;
        else        pls_q <= pls_d;
    end

    assign hs_out = cfg_pol_high ? pls_q.active : ~pls_q.active;

    // R7: an edge always (re)starts the pulse
    assert_start_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pls_q.active);

    // R5: a pulse ends only when its count is spent and no restart came
    assert_end_when_spent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pls_q.active) |-> (($past(pls_q.remain) == '0) && !$past(start)));
endmodule

// File: rtl/hsync_normalizer.sv
module hsync_normalizer
    import hsn_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LAT         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hsync_in,
    input  logic                   coast_in,
    input  logic [DATA_W-1:0]      pix_in,
    input  logic                   cfg_out_active_high,
    input  logic [HSN_WIDTH_W-1:0] cfg_pulse_width,
    output logic                   hsync_out,
    output logic                   ref_strobe,
    output logic [DATA_W-1:0]      pix_out,
    output logic                   pol_locked,
    output logic                   pol_active_high
);
    localparam int EDGE_DLY = LAT - SYNC_STAGES - 1;

    typedef struct packed {
        logic                       ref_stb;
        logic [LAT-1:0][DATA_W-1:0] pipe;
    } top_st_t;

    top_st_t    top_d, top_q;
    logic [1:0] sync_s;
    logic       hs_s, coast_s, active_edge;

    hsn_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({coast_in, hsync_in}),
        .q     (sync_s)
    );
    assign hs_s    = sync_s[0];
    assign coast_s = sync_s[1];

    hsn_pol_detect u_pol (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_s        (hs_s),
        .active_edge (active_edge),
        .pol_valid   (pol_locked),
        .pol_high    (pol_active_high)
    );

    hsn_pulse_gen #(.EDGE_DLY(EDGE_DLY)) u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_in      (active_edge),
        .cfg_width    (cfg_pulse_width),
        .cfg_pol_high (cfg_out_active_high),
        .hs_out       (hsync_out)
    );

    always_comb begin
        top_d         = top_q;
        top_d.ref_stb = active_edge & ~coast_s;
        top_d.pipe[0] = pix_in;
        for (int i = 1; i < LAT; i++) top_d.pipe[i] = top_q.pipe[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign ref_strobe = top_q.ref_stb;
    assign pix_out    = top_q.pipe[LAT-1];

    // R8: no strobe leaves while coast was seen
    assert_no_strobe_in_coast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> !$past(coast_s));

    // R9: strobes only after lock
    assert_strobe_after_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> pol_locked);
endmodule

// File: tb/hsync_normalizer_bench.sv
`timescale 1ns/1ps
module hsync_normalizer_bench;

    localparam int          PER  = 40;
    localparam logic [7:0]  MARK = 8'hA5;

    typedef struct packed {
        logic       act_high;
        logic [7:0] plen;
        logic       cfg_pol;
        logic [7:0] width;
        logic       exp_high;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 8'd4,  1'b1, 8'd8,  1'b1},
        '{1'b0, 8'd4,  1'b1, 8'd8,  1'b0},
        '{1'b1, 8'd6,  1'b0, 8'd12, 1'b1},
        '{1'b0, 8'd30, 1'b1, 8'd3,  1'b1},
        '{1'b1, 8'd5,  1'b1, 8'd0,  1'b1},
        '{1'b0, 8'd8,  1'b0, 8'd20, 1'b0},
        '{1'b1, 8'd20, 1'b1, 8'd4,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       coast_in = 1'b0;
    logic [7:0] pix_in = '0;
    logic       cfg_out_active_high = 1'b1;
    logic [7:0] cfg_pulse_width = 8'd8;
    logic       hsync_out, ref_strobe, pol_locked, pol_active_high;
    logic [7:0] pix_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic mon_en = 1'b0;
    logic prev_act = 1'b0;
    logic act_now;
    int   m_edges, m_act, m_misal, m_stb;

    always #2 clk = ~clk;

    hsync_normalizer u_hsync_normalizer (
        .clk                 (clk),
        .rst_n               (rst_n),
        .hsync_in            (hsync_in),
        .coast_in            (coast_in),
        .pix_in              (pix_in),
        .cfg_out_active_high (cfg_out_active_high),
        .cfg_pulse_width     (cfg_pulse_width),
        .hsync_out           (hsync_out),
        .ref_strobe          (ref_strobe),
        .pix_out             (pix_out),
        .pol_locked          (pol_locked),
        .pol_active_high     (pol_active_high)
    );

    always @(negedge clk) begin
        act_now = (hsync_out == cfg_out_active_high);
        if (mon_en) begin
            if (act_now && !prev_act) begin
                m_edges++;
                if (pix_out != MARK) m_misal++;
            end else if (pix_out == MARK) begin
                m_misal++;
            end
            if (act_now)    m_act++;
            if (ref_strobe) m_stb++;
        end
        prev_act = act_now;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mon_clear();
        m_edges = 0; m_act = 0; m_misal = 0; m_stb = 0;
    endtask

    task automatic drive_line(input logic lvl, input int plen, input int mark_at);
        for (int i = 0; i < PER; i++) begin
            @(posedge clk); #1;
            hsync_in = (i < plen) ? lvl : ~lvl;
            pix_in   = (i == mark_at) ? MARK : 8'h00;
        end
    endtask

    task automatic drive_restart_line();
        for (int i = 0; i < PER; i++) begin
            @(posedge clk); #1;
            hsync_in = (i < 2) || (i >= 5 && i < 7);
            pix_in   = (i == 0) ? MARK : 8'h00;
        end
    endtask

    task automatic do_reset(input logic idle);
        @(posedge clk); #1;
        rst_n = 1'b0; hsync_in = idle; coast_in = 1'b0; pix_in = '0; mon_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Table of vectors: polarity (R2), output polarity (R4), width (R5),
        // alignment (R6), strobes (R8)
        for (int v = 0; v < 7; v++) begin
            int mark_at;
            int w_eff;
            mark_at = (VECS[v].exp_high == VECS[v].act_high) ? 0 : int'(VECS[v].plen);
            w_eff   = (VECS[v].width == 0) ? 1 : int'(VECS[v].width);
            cfg_out_active_high = VECS[v].cfg_pol;
            cfg_pulse_width     = VECS[v].width;
            do_reset(~VECS[v].act_high);
            for (int l = 0; l < 4; l++) drive_line(VECS[v].act_high, VECS[v].plen, mark_at);
            mon_clear(); mon_en = 1'b1;
            for (int l = 0; l < 2; l++) drive_line(VECS[v].act_high, VECS[v].plen, mark_at);
            mon_en = 1'b0;
            chk($sformatf("R2 lock vec%0d", v), pol_locked, 1);
            chk($sformatf("R2 polarity vec%0d", v), pol_active_high, VECS[v].exp_high);
            chk($sformatf("R4 pulse count vec%0d", v), m_edges, 2);
            chk($sformatf("R5 active clocks vec%0d", v), m_act, 2 * w_eff);
            chk($sformatf("R6 alignment vec%0d", v), m_misal, 0);
            chk($sformatf("R8 strobes vec%0d", v), m_stb, 2);
        end

        // R1: reset state for both output polarities
        cfg_out_active_high = 1'b1; cfg_pulse_width = 8'd8;
        @(posedge clk); #1 rst_n = 1'b0; hsync_in = 1'b0; pix_in = 8'h3C;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R1 hsync_out idle high-mode", hsync_out, 0);
        chk("R1 pol_locked", pol_locked, 0);
        chk("R1 pol_active_high", pol_active_high, 0);
        chk("R1 ref_strobe", ref_strobe, 0);
        chk("R1 pix_out", pix_out, 0);
        cfg_out_active_high = 1'b0;
        @(negedge clk);
        chk("R1 hsync_out idle low-mode", hsync_out, 1);
        cfg_out_active_high = 1'b1;
        pix_in = 8'h00;
        @(posedge clk); #1 rst_n = 1'b1;

        // R9: two lines are not enough to lock, no output activity
        mon_clear(); mon_en = 1'b1;
        for (int l = 0; l < 2; l++) drive_line(1'b1, 4, 0);
        mon_en = 1'b0;
        chk("R9 not locked yet", pol_locked, 0);
        chk("R9 no pulse before lock", m_act, 0);
        chk("R9 no strobe before lock", m_stb, 0);
        for (int l = 0; l < 2; l++) drive_line(1'b1, 4, 0);
        chk("R2 locked high", pol_active_high, 1);

        // R3: one inverted line is rejected
        drive_line(1'b1, 36, -1);
        for (int l = 0; l < 3; l++) drive_line(1'b1, 4, 0);
        chk("R3 single odd line ignored", pol_active_high, 1);
        // R3: consecutive inverted lines flip the polarity
        for (int l = 0; l < 3; l++) drive_line(1'b1, 36, -1);
        drive_line(1'b1, 36, -1);
        chk("R3 two agreeing lines flip", pol_active_high, 0);
        for (int l = 0; l < 4; l++) drive_line(1'b1, 4, 0);
        chk("R3 flips back", pol_active_high, 1);

        // R7: restart within a running pulse
        cfg_pulse_width = 8'd20;
        drive_line(1'b1, 2, 0);
        mon_clear(); mon_en = 1'b1;
        drive_restart_line();
        mon_en = 1'b0;
        chk("R7 single leading edge", m_edges, 1);
        chk("R7 stretched width", m_act, 25);
        chk("R7 strobe per edge", m_stb, 2);
        chk("R7 alignment", m_misal, 0);
        drive_line(1'b1, 2, 0);

        // R8: coast blocks strobes but not output pulses
        cfg_pulse_width = 8'd6;
        coast_in = 1'b1;
        mon_clear(); mon_en = 1'b1;
        for (int l = 0; l < 2; l++) drive_line(1'b1, 4, 0);
        mon_en = 1'b0;
        chk("R8 no strobe in coast", m_stb, 0);
        chk("R8 pulses continue in coast", m_edges, 2);
        coast_in = 1'b0;
        mon_clear(); mon_en = 1'b1;
        for (int l = 0; l < 2; l++) drive_line(1'b1, 4, 0);
        mon_en = 1'b0;
        chk("R8 strobes resume", m_stb, 2);
        chk("R5 width after coast", m_act, 12);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule